// File: doc/BRIEF.md
# Burst Timeslot Scheduler

This block models the data phase of a DDR-style memory device. A read or write command reserves four consecutive entries in a circular table of data timeslots. The first reserved entry lies a fixed CAS latency ahead of the current position. A position pointer steps through the table once per clock. On each edge the block retires the entry under the pointer. A write entry stores the word on the write-data input into a small internal word store, unless the data mask is high. A read entry presents the word that was fetched from the store on the edge that issued the command.

The returned word depends on the output-enable input. When output-enable is low, the block returns the read entry's stored word. When it is high, it returns the write data being driven. The block raises an error pulse when a write entry retires while output-enable is low. It raises the same pulse when any occupied entry points past the end of the store. A bank tracker outside the block supplies the row for each command. Refresh and bank open/close handling stay outside the block.

Each table entry is a small state machine with three states: FREE, READ and WRITE. A command moves the four targeted entries from any state to READ or to WRITE. A later command aimed at the same entries replaces them. When the pointer retires an entry, the entry returns to FREE.

Top module: `burst_timeslot_sched`

## Requirements
- R1: While reset is low, `rdata_o` and `err_o` read zero, whatever the other inputs are.
- R2: A command sampled on edge E occupies the slots that retire on edges E+5, E+6, E+7 and E+8, carrying words 0 to 3 in that order. Each result appears on the outputs just after its retiring edge, and nothing of the burst shows before E+5 or after E+8.
- R3: The burst base address is the concatenation {row, bank, column}, with the row in the most significant bits and the two least significant bits forced to zero. Word i uses address base+i, so a column of 4, 5, 6 or 7 gives the same burst.
- R4: A read slot that retires with `oe_i` low puts its stored word on `rdata_o`.
- R5: A write slot that retires with `dmask_i` low stores `wdata_i` at the slot address. With `dmask_i` high, that word of the store keeps its previous value.
- R6: While `oe_i` is high, a retiring edge loads the current `wdata_i` into `rdata_o`.
- R7: A write slot that retires while `oe_i` is low drives `err_o` high for that one result cycle.
- R8: An occupied slot whose address is at or above DEPTH drives `err_o` high when it retires. Such a read returns zero, and such a write leaves the store unchanged, even at the address it would alias to after truncation.
- R9: A read takes its data from the store on the edge that issues it. A write that retires between that edge and the read's slots does not change the returned words.
- R10: A command that reserves slots already held by an earlier burst replaces those slots. The earlier burst's remaining words are neither written nor flagged.
- R11: The command code on `cmd_i` is 2'b01 for read and 2'b10 for write. Codes 2'b00 and 2'b11 reserve nothing. A free slot that retires with `oe_i` low returns zero and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Command code: 01 read, 10 write, others none |
| row_i | input | ROW_W | Row from the external bank tracker |
| bank_i | input | BANK_W | Bank of the command |
| col_i | input | COL_W | Column of the command |
| wdata_i | input | DW | Write data driven toward the memory |
| dmask_i | input | 1 | Data mask for the retiring write word |
| oe_i | input | 1 | High while the controller drives the data bus |
| rdata_o | output | DW | Word returned for the retiring slot |
| err_o | output | 1 | Bus-direction or address-range error pulse |

## Verification
A pointer that skips or repeats a step moves a whole burst to other cycles. That shows at the ports five to eight cycles after the command, as data one cycle early or late. A wrong slot state shows on the retiring edge: a write left marked as read returns data instead of zero, and a wrong kind or a stale entry raises or drops `err_o` one cycle after that slot's edge. A fault in address composition or in the store only appears when the burst is read back. For that reason every write test reads the location back, and the overlap test checks that the replaced words were never written.

// File: rtl/burst_sched_pkg.sv
package burst_sched_pkg;

    // words per burst; the base address clears log2 of this many LSBs
    localparam int BURST_LEN = 4;

    typedef enum logic [1:0] {
        SK_FREE  = 2'd0,
        SK_READ  = 2'd1,
        SK_WRITE = 2'd2
    } slot_kind_e;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_SPARE = 2'b11
    } cmd_e;

endpackage

// File: rtl/burst_word_store.sv
module burst_word_store
    import burst_sched_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 9,
    parameter int DEPTH = 96
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [$clog2(DEPTH)-1:0]      wr_idx,
    input  logic [DW-1:0]                 wr_data,
    input  logic [AW-1:0]                 rd_base,
    output logic [BURST_LEN-1:0][DW-1:0]  rd_words
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // one read port per burst word; out-of-range words read as zero
    for (genvar w = 0; w < BURST_LEN; w++) begin : g_rd
        logic [AW-1:0] addr;
        assign addr = rd_base + AW'(w);
        assign rd_words[w] = ({1'b0, addr} < LIMIT) ? mem[addr[IDX_W-1:0]] : '0;
    end

endmodule

// File: rtl/burst_slot_table.sv
module burst_slot_table
    import burst_sched_pkg::*;
#(
    parameter int NSLOT   = 16,
    parameter int CAS_LAT = 5,
    parameter int DW      = 16,
    parameter int AW      = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          book_en,
    input  logic                          book_read,
    input  logic [AW-1:0]                 book_base,
    input  logic [BURST_LEN-1:0][DW-1:0]  book_words,
    output logic [$clog2(NSLOT)-1:0]      ptr,
    output slot_kind_e                    cur_kind,
    output logic [AW-1:0]                 cur_addr,
    output logic [DW-1:0]                 cur_data
);
    localparam int PTR_W = $clog2(NSLOT);
    localparam int BW    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    slot_kind_e    kind_arr [NSLOT];
    logic [AW-1:0] addr_arr [NSLOT];
    logic [DW-1:0] data_arr [NSLOT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            ptr <= ptr + 1'b1;
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [PTR_W-1:0] rel;     // distance of this slot past the first booked one
        logic             hit;
        slot_kind_e       kind_q;
        logic [AW-1:0]    addr_q;
        logic [DW-1:0]    data_q;

        assign rel = PTR_W'(s) - ptr - PTR_W'(CAS_LAT);
        assign hit = book_en && ({1'b0, rel} < (PTR_W+1)'(BURST_LEN));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                kind_q <= SK_FREE;
                addr_q <= '0;
                data_q <= '0;
            end else if (hit) begin
                kind_q <= book_read ? SK_READ : SK_WRITE;
                addr_q <= book_base + AW'(rel);
                data_q <= book_read ? book_words[rel[BW-1:0]] : '0;
            end else if (PTR_W'(s) == ptr) begin
                kind_q <= SK_FREE;
            end
        end

        assign kind_arr[s] = kind_q;
        assign addr_arr[s] = addr_q;
        assign data_arr[s] = data_q;
    end

    assign cur_kind = kind_arr[ptr];
    assign cur_addr = addr_arr[ptr];
    assign cur_data = data_arr[ptr];

endmodule

// File: rtl/burst_retire_unit.sv
module burst_retire_unit
    import burst_sched_pkg::*;
#(
    parameter int DW    = 16,
    parameter int AW    = 9,
    parameter int DEPTH = 96
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  slot_kind_e                cur_kind,
    input  logic [AW-1:0]             cur_addr,
    input  logic [DW-1:0]             cur_data,
    input  logic [DW-1:0]             wdata,
    input  logic                      dmask,
    input  logic                      oe,
    output logic                      wr_en,
    output logic [$clog2(DEPTH)-1:0]  wr_idx,
    output logic [DW-1:0]             rdata_q,
    output logic                      err_q
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic          in_range;
    logic [DW-1:0] rd_next;
    logic          err_next;

    assign in_range = ({1'b0, cur_addr} < LIMIT);
    assign wr_idx   = cur_addr[IDX_W-1:0];

    always_comb begin
        wr_en    = 1'b0;
        rd_next  = '0;
        err_next = 1'b0;
        unique case (cur_kind)
            SK_FREE: begin
            end
            SK_READ: begin
                rd_next  = cur_data;
                err_next = !in_range;
            end
            SK_WRITE: begin
                wr_en    = !dmask && in_range;
                err_next = !oe || !in_range;
            end
            default: begin
            end
        endcase
        if (oe) begin
            rd_next = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= rd_next;
            err_q   <= err_next;
        end
    end

endmodule

// File: rtl/burst_timeslot_sched.sv
module burst_timeslot_sched
    import burst_sched_pkg::*;
#(
    parameter int NSLOT   = 16,
    parameter int CAS_LAT = 5,
    parameter int DW      = 16,
    parameter int ROW_W   = 3,
    parameter int BANK_W  = 2,
    parameter int COL_W   = 4,
    parameter int DEPTH   = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic              dmask_i,
    input  logic              oe_i,
    output logic [DW-1:0]     rdata_o,
    output logic              err_o
);
    localparam int AW    = ROW_W + BANK_W + COL_W;
    localparam int PTR_W = $clog2(NSLOT);
    localparam int IDX_W = $clog2(DEPTH);

    initial begin
        if ((1 << PTR_W) != NSLOT)          $error("NSLOT must be a power of two");
        if (CAS_LAT + BURST_LEN > NSLOT)    $error("burst would wrap onto the retiring slot");
        if (DEPTH > (1 << AW))              $error("DEPTH exceeds the address space");
    end

    logic                         book_en;
    logic                         book_read;
    logic [AW-1:0]                base;
    logic [BURST_LEN-1:0][DW-1:0] fetch_words;
    logic [PTR_W-1:0]             ptr;
    slot_kind_e                   cur_kind;
    logic [AW-1:0]                cur_addr;
    logic [DW-1:0]                cur_data;
    logic                         wr_en;
    logic [IDX_W-1:0]             wr_idx;

    always_comb begin
        book_en   = 1'b0;
        book_read = 1'b0;
        unique case (cmd_e'(cmd_i))
            CMD_READ:  begin book_en = 1'b1; book_read = 1'b1; end
            CMD_WRITE: begin book_en = 1'b1; end
            CMD_IDLE, CMD_SPARE: begin end
            default: begin end
        endcase
    end

    assign base = {row_i, bank_i, col_i} & ~AW'(BURST_LEN - 1);

    burst_word_store #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wdata_i),
        .rd_base  (base),
        .rd_words (fetch_words)
    );

    burst_slot_table #(.NSLOT(NSLOT), .CAS_LAT(CAS_LAT), .DW(DW), .AW(AW)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .book_en    (book_en),
        .book_read  (book_read),
        .book_base  (base),
        .book_words (fetch_words),
        .ptr        (ptr),
        .cur_kind   (cur_kind),
        .cur_addr   (cur_addr),
        .cur_data   (cur_data)
    );

    burst_retire_unit #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_retire (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_kind (cur_kind),
        .cur_addr (cur_addr),
        .cur_data (cur_data),
        .wdata    (wdata_i),
        .dmask    (dmask_i),
        .oe       (oe_i),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .rdata_q  (rdata_o),
        .err_q    (err_o)
    );

endmodule

// File: rtl/burst_sched_chk.sv
module burst_sched_chk
    import burst_sched_pkg::*;
#(
    parameter int DW    = 16,
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             oe_i,
    input logic [DW-1:0]    wdata_i,
    input logic [DW-1:0]    rdata_o,
    input logic             err_o,
    input slot_kind_e       cur_kind,
    input logic [DW-1:0]    cur_data,
    input logic [PTR_W-1:0] ptr
);
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ptr == PTR_W'($past(ptr) + 1'b1)); // R2

    AST_WRITE_OE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_kind == SK_WRITE && !oe_i) |=> err_o); // R7

    AST_ERR_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(cur_kind) != SK_FREE); // R8

    AST_READ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_kind == SK_READ && !oe_i) |=> rdata_o == $past(cur_data)); // R4

    AST_OE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        oe_i |=> rdata_o == $past(wdata_i)); // R6

    AST_FREE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_kind == SK_FREE && !oe_i) |=> (rdata_o == '0 && !err_o)); // R11

endmodule

bind burst_timeslot_sched burst_sched_chk #(.DW(DW), .PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_i     (oe_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .err_o    (err_o),
    .cur_kind (cur_kind),
    .cur_data (cur_data),
    .ptr      (ptr)
);

// File: tb/sim_burst_timeslot_sched.sv
module sim_burst_timeslot_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd = 2'b00;
    logic [2:0]  row = '0;
    logic [1:0]  bank = '0;
    logic [3:0]  colv = '0;
    logic [15:0] wdata = '0;
    logic        dmask = 1'b0;
    logic        oe = 1'b0;
    logic [15:0] rdata;
    logic        err;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    localparam logic [1:0] C_IDLE = 2'b00, C_RD = 2'b01, C_WR = 2'b10, C_SPARE = 2'b11;

    always #5 clk = ~clk;

    burst_timeslot_sched u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .row_i(row), .bank_i(bank),
        .col_i(colv), .wdata_i(wdata), .dmask_i(dmask), .oe_i(oe),
        .rdata_o(rdata), .err_o(err)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic [1:0] c, input logic [2:0] r, input logic [1:0] b,
                        input logic [3:0] cl, input logic [15:0] wd, input logic m,
                        input logic o);
        cmd = c; row = r; bank = b; colv = cl; wdata = wd; dmask = m; oe = o;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n, input logic o);
        for (int i = 0; i < n; i++) tick(C_IDLE, 0, 0, 0, 16'h0, 1'b0, o);
    endtask

    // read a burst with oe low and compare each word (mask bit i skips word i)
    task automatic read_burst(input string req, input logic [2:0] r, input logic [1:0] b,
                              input logic [3:0] cl, input logic [63:0] exp, input logic [3:0] skip);
        tick(C_RD, r, b, cl, 16'h0, 1'b0, 1'b0);
        idle(4, 1'b0);
        chk({req, " before latency"}, rdata, 16'h0);
        for (int i = 0; i < 4; i++) begin
            idle(1, 1'b0);
            if (!skip[i]) chk(req, rdata, exp[16*i +: 16]);
            chk({req, " err"}, {15'h0, err}, 16'h0);
        end
        idle(1, 1'b0);
        chk({req, " after burst"}, rdata, 16'h0);
    endtask

    task automatic write_burst(input logic [2:0] r, input logic [1:0] b, input logic [3:0] cl,
                               input logic [63:0] data, input logic [3:0] mask);
        tick(C_WR, r, b, cl, 16'h0, 1'b0, 1'b1);
        idle(4, 1'b1);
        for (int i = 0; i < 4; i++) begin
            tick(C_IDLE, 0, 0, 0, data[16*i +: 16], mask[i], 1'b1);
            chk("R6 echo", rdata, data[16*i +: 16]);
            chk("R6 no err", {15'h0, err}, 16'h0);
        end
    endtask

    task automatic t_reset;
        wdata = 16'hBEEF; oe = 1'b1; cmd = C_RD;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 rdata in reset", rdata, 16'h0);
        chk("R1 err in reset", {15'h0, err}, 16'h0);
        cmd = C_IDLE; oe = 1'b0; wdata = '0;
        rst_n = 1'b1;
        idle(2, 1'b0);
    endtask

    // base = {row,bank,col} with LSBs cleared: row0 bank1 col5 -> 20
    task automatic t_write_read;
        write_burst(0, 1, 5, 64'h1103_1102_1101_1100, 4'b0000);
        read_burst("R2 R3 R4 read back", 0, 1, 6, 64'h1103_1102_1101_1100, 4'b0000);
    endtask

    task automatic t_capture;
        tick(C_WR, 0, 1, 4, 16'h0, 1'b0, 1'b1);            // E0
        idle(3, 1'b1);                                      // E1..E3
        tick(C_RD, 0, 1, 4, 16'h0, 1'b0, 1'b1);            // E4
        for (int i = 0; i < 4; i++)                         // E5..E8 write retires
            tick(C_IDLE, 0, 0, 0, 16'h2200 + 16'(i), 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) begin                   // E9..E12 read retires
            idle(1, 1'b0);
            chk("R9 old data", rdata, 16'h1100 + 16'(i));
        end
        read_burst("R9 R5 new data", 0, 1, 7, 64'h2203_2202_2201_2200, 4'b0000);
    endtask

    task automatic t_mask;
        write_burst(0, 2, 8, 64'h3303_3302_3301_3300, 4'b0000);
        write_burst(0, 2, 9, 64'h4403_4402_4401_4400, 4'b0010);
        read_burst("R5 masked word kept", 0, 2, 8, 64'h4403_4402_3301_4400, 4'b0000);
    endtask

    task automatic t_oe_err;
        tick(C_WR, 0, 3, 12, 16'h0, 1'b0, 1'b1);
        idle(4, 1'b0);
        chk("R7 no early err", {15'h0, err}, 16'h0);
        for (int i = 0; i < 4; i++) begin
            tick(C_IDLE, 0, 0, 0, 16'h5500, 1'b0, 1'b0);
            chk("R7 write with oe low", {15'h0, err}, 16'h1);
        end
        idle(1, 1'b0);
        chk("R7 err clears", {15'h0, err}, 16'h0);
    endtask

    task automatic t_range;
        // row2 bank0 col0 -> 128, beyond DEPTH 96
        tick(C_RD, 2, 0, 0, 16'h0, 1'b0, 1'b0);
        idle(4, 1'b0);
        for (int i = 0; i < 4; i++) begin
            idle(1, 1'b0);
            chk("R8 range err read", {15'h0, err}, 16'h1);
            chk("R8 range read zero", rdata, 16'h0);
        end
        // row2 bank1 col4 -> 148, aliases 20 after truncation
        tick(C_WR, 2, 1, 4, 16'h0, 1'b0, 1'b1);
        idle(4, 1'b1);
        for (int i = 0; i < 4; i++) begin
            tick(C_IDLE, 0, 0, 0, 16'h6600 + 16'(i), 1'b0, 1'b1);
            chk("R8 range err write", {15'h0, err}, 16'h1);
        end
        read_burst("R8 alias untouched", 0, 1, 4, 64'h2203_2202_2201_2200, 4'b0000);
    endtask

    task automatic t_overwrite;
        tick(C_WR, 1, 0, 8, 16'h0, 1'b0, 1'b1);            // E0, base 72
        idle(1, 1'b1);                                      // E1
        tick(C_RD, 0, 1, 4, 16'h0, 1'b0, 1'b1);            // E2, base 20
        idle(2, 1'b1);                                      // E3, E4
        tick(C_IDLE, 0, 0, 0, 16'h7700, 1'b0, 1'b1);       // E5
        tick(C_IDLE, 0, 0, 0, 16'h7701, 1'b0, 1'b1);       // E6
        for (int i = 0; i < 4; i++) begin                   // E7..E10
            tick(C_IDLE, 0, 0, 0, 16'h7777, 1'b0, 1'b0);
            chk("R10 later read wins", rdata, 16'h2200 + 16'(i));
            chk("R10 no err", {15'h0, err}, 16'h0);
        end
        read_burst("R10 early words kept", 1, 0, 8, 64'h0000_0000_7701_7700, 4'b1100);
    endtask

    task automatic t_idle;
        tick(C_SPARE, 0, 1, 4, 16'h8888, 1'b0, 1'b0);
        for (int i = 0; i < 9; i++) begin
            tick(C_IDLE, 0, 1, 4, 16'h8888, 1'b0, 1'b0);
            chk("R11 spare code idle data", rdata, 16'h0);
            chk("R11 spare code idle err", {15'h0, err}, 16'h0);
        end
        read_burst("R11 store unchanged", 0, 1, 4, 64'h2203_2202_2201_2200, 4'b0000);
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_capture();
        t_mask();
        t_oe_err();
        t_range();
        t_overwrite();
        t_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule